// File: doc/BRIEF.md
# Window Threshold Interrupt Generator

This block watches a stream of 16-bit conversion results from the first sensing channel and raises an interrupt line when a result lands outside a programmable window. The window has a lower bound and an upper bound. Each bound is written one byte at a time through a simple byte-wide register write port. A result at or below the lower bound, or strictly above the upper bound, counts as a violation.

A comparison happens only in the cycle where the result-valid strobe is high. It uses the bound values held in the registers at that moment. The interrupt output is sticky: once set, it stays high until a clear pulse arrives. A violation in the same cycle as the clear wins, so the interrupt stays set. The block has no filtering or persistence counting, and it never looks at any other channel.

Top module: `win_thresh_irq`

## Requirements
- R1: After reset, the interrupt output is 0 and all four threshold bytes are 0x00.
- R2: A write with `wr_en` high stores `wr_data` in one byte slot. Address 2 is the lower bound's bits 7:0, address 3 its bits 15:8, address 4 the upper bound's bits 7:0, and address 5 its bits 15:8. Each bound is {high byte, low byte}.
- R3: A write to any address other than 2 through 5 changes no bound.
- R4: A strobed result less than or equal to the lower bound sets the interrupt. The interrupt is visible on the clock edge that samples the strobe.
- R5: A strobed result strictly greater than the upper bound sets the interrupt on the same edge.
- R6: A strobed result above the lower bound and at or below the upper bound does not set the interrupt.
- R7: With the strobe low, the result input has no effect on the interrupt, whatever its value.
- R8: A set interrupt stays high through later in-window results. It falls only on the edge after a clear pulse.
- R9: If a clear and a violating strobe occur in the same cycle, the interrupt is high after that edge.
- R10: A byte write in the same cycle as a strobe does not affect that comparison. It applies from the next strobe onward.
- R11: With both bounds at their reset value of 0, every strobed result sets the interrupt, both 0 and any nonzero value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Byte write enable |
| wr_addr | input | 4 | Byte address of the write |
| wr_data | input | 8 | Byte to store |
| res_valid | input | 1 | Result-valid strobe, one cycle per result |
| res_data | input | 16 | Conversion result of the first channel |
| irq_clr | input | 1 | Clear pulse for the interrupt |
| irq | output | 1 | Sticky out-of-window interrupt |

## Verification
The checker assumes that every input is stable and free of X around the sampling edge. It also assumes that `res_data` is meaningful only while `res_valid` is high, so the comparison properties are gated by the strobe. The bench drives every input on the falling clock edge, so each value is settled well before the rising edge that samples it. It keeps `res_valid` and `irq_clr` as single-cycle pulses, except in the cases that deliberately combine them or overlap them with a byte write.

// File: rtl/win_thresh_pkg.sv
package win_thresh_pkg;

   // Number of bounds held by the block: one lower and one upper.
   localparam int unsigned NUM_BOUNDS = 2;

   // Bound index: lower first, then upper. This order follows the byte addresses.
   typedef enum logic {
      BOUND_LOWER = 1'b0,
      BOUND_UPPER = 1'b1
   } bound_e;

   // Number of byte slots needed to hold a value of data_w bits.
   function automatic int unsigned slots_per_bound(input int unsigned data_w,
                                                   input int unsigned byte_w);
      return (data_w + byte_w - 1) / byte_w;
   endfunction

endpackage

// File: rtl/wt_byte_store.sv
module wt_byte_store #(
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned BASE_ADDR = 2,
   parameter int unsigned NSLOT     = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [BYTE_W-1:0]       wr_data,
   output logic [NSLOT*BYTE_W-1:0] slots_flat
);

   // One register per byte slot. Slot k answers at address BASE_ADDR + k.
   for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(BASE_ADDR + k);
      logic              hit;
      logic [BYTE_W-1:0] byte_q;

      assign hit = wr_en && (wr_addr == SLOT_ADDR);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
         end else if (hit) begin
            byte_q <= wr_data;
         end
      end

      assign slots_flat[k*BYTE_W +: BYTE_W] = byte_q;
   end

endmodule

// File: rtl/wt_window_cmp.sv
module wt_window_cmp #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              res_valid,
   input  logic [DATA_W-1:0] res_data,
   input  logic [DATA_W-1:0] lo_bound,
   input  logic [DATA_W-1:0] hi_bound,
   output logic              violation
);

   logic at_or_below;
   logic strictly_above;

   // The lower edge counts as outside the window; the upper edge counts as inside.
   always_comb begin
      at_or_below    = (res_data <= lo_bound);
      strictly_above = (res_data >  hi_bound);
      violation      = res_valid && (at_or_below || strictly_above);
   end

endmodule

// File: rtl/wt_sticky_flag.sv
module wt_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;

   // A set request overrides a clear in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (set_i) begin
         flag_q <= 1'b1;
      end else if (clr_i) begin
         flag_q <= 1'b0;
      end
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/win_thresh_irq.sv
module win_thresh_irq
   import win_thresh_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned BASE_ADDR = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              res_valid,
   input  logic [DATA_W-1:0] res_data,
   input  logic              irq_clr,
   output logic              irq
);

   localparam int unsigned SLOTS_PER = slots_per_bound(DATA_W, BYTE_W);
   localparam int unsigned NSLOT     = NUM_BOUNDS * SLOTS_PER;
   localparam int unsigned STORE_W   = NSLOT * BYTE_W;

   // Elaboration-time parameter checks
   if (DATA_W % BYTE_W != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of bytes");
   end
   if (BASE_ADDR + NSLOT > (1 << ADDR_W)) begin : g_bad_addr
      $error("threshold slots do not fit in the address space");
   end

   logic [STORE_W-1:0] slots_flat;
   logic [DATA_W-1:0]  lo_thr;
   logic [DATA_W-1:0]  hi_thr;
   logic               violation;

   wt_byte_store #(
      .BYTE_W    (BYTE_W),
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR),
      .NSLOT     (NSLOT)
   ) store_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .slots_flat (slots_flat)
   );

   // Lower byte addresses hold the less significant bytes; the lower bound comes first.
   assign lo_thr = slots_flat[int'(BOUND_LOWER)*DATA_W +: DATA_W];
   assign hi_thr = slots_flat[int'(BOUND_UPPER)*DATA_W +: DATA_W];

   wt_window_cmp #(
      .DATA_W (DATA_W)
   ) cmp_i (
      .res_valid (res_valid),
      .res_data  (res_data),
      .lo_bound  (lo_thr),
      .hi_bound  (hi_thr),
      .violation (violation)
   );

   wt_sticky_flag flag_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (violation),
      .clr_i  (irq_clr),
      .flag_o (irq)
   );

endmodule

// File: rtl/win_thresh_irq_chk.sv
module win_thresh_irq_chk #(
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              res_valid,
   input logic [DATA_W-1:0] res_data,
   input logic              irq_clr,
   input logic              irq,
   input logic [DATA_W-1:0] lo_thr,
   input logic [DATA_W-1:0] hi_thr
);

   // R1
   always @(negedge clk) begin
      if (!rst_n) begin
         reset_quiet_chk: assert (irq == 1'b0);
      end
   end

   // R4
   low_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && (res_data <= lo_thr)) |=> irq);

   // R5
   high_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && (res_data > hi_thr)) |=> irq);

   // R6
   in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && res_valid && (res_data > lo_thr) && (res_data <= hi_thr)) |=> !irq);

   // R7
   quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!res_valid && !irq) |=> !irq);

   // R8
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

   // R8
   clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(irq_clr));

   // R9
   set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(res_valid));

endmodule

bind win_thresh_irq win_thresh_irq_chk #(.DATA_W(DATA_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .res_valid (res_valid),
   .res_data  (res_data),
   .irq_clr   (irq_clr),
   .irq       (irq),
   .lo_thr    (lo_thr),
   .hi_thr    (hi_thr)
);

// File: tb/win_thresh_irq_tb_top.sv
module win_thresh_irq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [3:0]  wr_addr;
   logic [7:0]  wr_data;
   logic        res_valid;
   logic [15:0] res_data;
   logic        irq_clr;
   logic        irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   win_thresh_irq dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .res_valid (res_valid),
      .res_data  (res_data),
      .irq_clr   (irq_clr),
      .irq       (irq)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: irq=%0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic write_byte(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic strobe(input logic [15:0] v);
      @(negedge clk);
      res_valid = 1'b1; res_data = v;
      @(negedge clk);
      res_valid = 1'b0;
   endtask

   task automatic clear_irq();
      @(negedge clk);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
   endtask

   task automatic set_bounds(input logic [15:0] lo, input logic [15:0] hi);
      write_byte(4'd2, lo[7:0]);
      write_byte(4'd3, lo[15:8]);
      write_byte(4'd4, hi[7:0]);
      write_byte(4'd5, hi[15:8]);
   endtask

   task automatic t_reset_state();
      check("R1 reset", irq, 1'b0);
      strobe(16'h0000);
      check("R11 zero result, zero bounds", irq, 1'b1);
      clear_irq();
      check("R8 clear", irq, 1'b0);
      strobe(16'h1234);
      check("R11 nonzero result, zero bounds", irq, 1'b1);
      clear_irq();
   endtask

   task automatic t_window();
      set_bounds(16'h0100, 16'h8000);
      clear_irq();
      strobe(16'h0100);
      check("R4 equal to low (R2 byte order)", irq, 1'b1);
      clear_irq();
      strobe(16'h0101);
      check("R6 just above low", irq, 1'b0);
      strobe(16'h8000);
      check("R6 equal to high", irq, 1'b0);
      strobe(16'h8001);
      check("R5 above high (R2 byte order)", irq, 1'b1);
      clear_irq();
      strobe(16'h00FF);
      check("R4 below low", irq, 1'b1);
      clear_irq();
   endtask

   task automatic t_other_addr();
      write_byte(4'd0, 8'hFF);
      write_byte(4'd1, 8'hFF);
      write_byte(4'd6, 8'hFF);
      write_byte(4'd7, 8'hFF);
      write_byte(4'd15, 8'hFF);
      strobe(16'h0101);
      check("R3 low bound unchanged", irq, 1'b0);
      strobe(16'h8000);
      check("R3 high bound unchanged", irq, 1'b0);
   endtask

   task automatic t_no_strobe();
      @(negedge clk);
      res_data = 16'h0000;
      repeat (4) @(negedge clk);
      check("R7 low value without strobe", irq, 1'b0);
      res_data = 16'hFFFF;
      repeat (4) @(negedge clk);
      check("R7 high value without strobe", irq, 1'b0);
   endtask

   task automatic t_sticky();
      strobe(16'hFFFF);
      check("R5 trigger", irq, 1'b1);
      strobe(16'h4000);
      strobe(16'h2000);
      repeat (3) @(negedge clk);
      check("R8 stays set", irq, 1'b1);
      clear_irq();
      check("R8 cleared", irq, 1'b0);
   endtask

   task automatic t_clear_collide();
      strobe(16'h0010);
      check("R4 trigger before collision", irq, 1'b1);
      @(negedge clk);
      irq_clr = 1'b1; res_valid = 1'b1; res_data = 16'h0005;
      @(negedge clk);
      irq_clr = 1'b0; res_valid = 1'b0;
      check("R9 clear with violation", irq, 1'b1);
      @(negedge clk);
      irq_clr = 1'b1; res_valid = 1'b1; res_data = 16'h0500;
      @(negedge clk);
      irq_clr = 1'b0; res_valid = 1'b0;
      check("R6 clear with in-window result", irq, 1'b0);
   endtask

   task automatic t_write_collide();
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd3; wr_data = 8'h02;
      res_valid = 1'b1; res_data = 16'h0150;
      @(negedge clk);
      wr_en = 1'b0; res_valid = 1'b0;
      check("R10 old bound used", irq, 1'b0);
      strobe(16'h0150);
      check("R10 new bound on next strobe", irq, 1'b1);
      clear_irq();
   endtask

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      res_valid = 1'b0; res_data = '0; irq_clr = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 during reset", irq, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_window();
      t_other_addr();
      t_no_strobe();
      t_sticky();
      t_clear_collide();
      t_write_collide();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: done=0 expected 1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule